// File: doc/BRIEF.md
# Fetch Stall Stash Buffer

This stage sits between an instruction cache that cannot be held and an instruction decoder that can stall. Every cycle the cache may present one fetched entry: a valid bit, a stop marker, a 64-bit instruction address and a 32-bit instruction word. The stage registers that entry and hands it to the decoder one cycle later.

The cache reacts to a stall one cycle late, so the entry already in flight arrives while the decoder is stalled. The stage catches that entry in a one-entry side register, the stash. It holds its own output steady for the whole stall. On the first cycle after the stall drops, it sends the stashed entry ahead of anything arriving live. If a live entry arrives in that same cycle, it takes the stash's place, so the entry order never changes. A flush input, used on a redirect, discards both the held output and the stash at once.

Top module: `fetch_stash`

## Requirements
- R1: While reset is asserted, the output is invalid, the stop marker is 0, and the address and instruction fields are all zero.
- R2: With no stall, no flush and an empty stash, an input entry appears on the output one clock edge later with all four fields unchanged, stop marker included.
- R3: On every edge where stall is high and flush is low, the output keeps all four fields unchanged.
- R4: A valid input that arrives while stall is high, flush is low and the stash is empty is captured in the stash and is not lost.
- R5: On the first edge with stall low after a capture, the output takes the stashed entry rather than the live input.
- R6: A valid live input that arrives in the same cycle as a stash replay is kept in the stash and reaches the output on the following non-stalled edge, so the order is preserved.
- R7: Flush takes priority over stall. On the edge after it, the output is invalid, the stash is empty, and the input presented in the flush cycle is dropped.
- R8: Across any mix of stalls and gaps, every accepted entry appears on the output exactly once and in arrival order, with its stop marker.
- R9: On a non-stalled edge with nothing stashed and no valid input, the output becomes invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard the held output and the stash (redirect) |
| stall_i | input | 1 | Decoder stall |
| in_valid_i | input | 1 | Cache entry valid |
| in_stop_i | input | 1 | Cache entry stop marker |
| in_addr_i | input | 64 | Cache entry instruction address |
| in_insn_i | input | 32 | Cache entry instruction word |
| out_valid_o | output | 1 | Entry to decoder valid |
| out_stop_o | output | 1 | Entry to decoder stop marker |
| out_addr_o | output | 64 | Entry to decoder instruction address |
| out_insn_o | output | 32 | Entry to decoder instruction word |

## Verification
The output is a single register. Every result therefore shows up exactly one rising edge after the inputs that cause it: a pass-through, a hold, a flush or a replay. A replacement entry placed in the stash during a replay shows up one non-stalled edge after that. The bench drives the inputs on the falling edge, waits for the next rising edge, and samples on the falling edge that follows. At that point it compares the output against a queue of accepted entries, or against the previous sample when the edge was stalled. Because the queue is popped only on non-stalled edges, it also checks that a stashed entry shows up late but never twice.

// File: rtl/fetch_stash_pkg.sv
package fetch_stash_pkg;

  typedef enum logic {
    SRC_LIVE  = 1'b0,
    SRC_STASH = 1'b1
  } fs_src_e;

  typedef struct packed {
    logic    out_load;
    logic    out_clr;
    fs_src_e out_src;
    logic    stash_load;
    logic    stash_clr;
  } fs_ctrl_t;

endpackage

// File: rtl/fs_slot.sv
module fs_slot #(
  parameter int W = 97
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clr,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);

  logic         valid_nxt;
  logic [W-1:0] data_nxt;

  always_comb begin
    valid_nxt = q_valid;
    data_nxt  = q_data;
    if (clr) begin
      valid_nxt = 1'b0;
    end else if (load) begin
      valid_nxt = d_valid;
      data_nxt  = d_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= valid_nxt;
      q_data  <= data_nxt;
    end
  end

endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fetch_stash_pkg::*;
(
  input  logic     flush,
  input  logic     stall,
  input  logic     in_valid,
  input  logic     stash_valid,
  output fs_ctrl_t ctrl
);

  always_comb begin
    ctrl = '{out_load: 1'b0, out_clr: 1'b0, out_src: SRC_LIVE,
             stash_load: 1'b0, stash_clr: 1'b0};
    if (flush) begin
      ctrl.out_clr   = 1'b1;
      ctrl.stash_clr = 1'b1;
    end else if (stall) begin
      ctrl.stash_load = in_valid & ~stash_valid;
    end else begin
      ctrl.out_load = 1'b1;
      if (stash_valid) begin
        ctrl.out_src    = SRC_STASH;
        ctrl.stash_load = in_valid;
        ctrl.stash_clr  = ~in_valid;
      end
    end
  end

endmodule

// File: rtl/fetch_stash.sv
module fetch_stash #(
  parameter int ADDR_W = 64,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              stall_i,
  input  logic              in_valid_i,
  input  logic              in_stop_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [INSN_W-1:0] in_insn_i,
  output logic              out_valid_o,
  output logic              out_stop_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [INSN_W-1:0] out_insn_o
);
  import fetch_stash_pkg::*;

  localparam int PW = 1 + ADDR_W + INSN_W;

  fs_ctrl_t        ctrl;
  logic [PW-1:0]   live_pay;
  logic            stash_valid;
  logic [PW-1:0]   stash_pay;
  logic [ADDR_W-1:0] stash_addr;
  logic            out_d_valid;
  logic [PW-1:0]   out_d_pay;
  logic [PW-1:0]   out_pay;

  assign live_pay   = {in_stop_i, in_addr_i, in_insn_i};
  assign stash_addr = stash_pay[INSN_W +: ADDR_W];

  fs_ctrl u_ctrl (
    .flush       (flush_i),
    .stall       (stall_i),
    .in_valid    (in_valid_i),
    .stash_valid (stash_valid),
    .ctrl        (ctrl)
  );

  always_comb begin
    if (ctrl.out_src == SRC_STASH) begin
      out_d_valid = stash_valid;
      out_d_pay   = stash_pay;
    end else begin
      out_d_valid = in_valid_i;
      out_d_pay   = live_pay;
    end
  end

  fs_slot #(.W(PW)) u_stash (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctrl.stash_load),
    .clr     (ctrl.stash_clr),
    .d_valid (in_valid_i),
    .d_data  (live_pay),
    .q_valid (stash_valid),
    .q_data  (stash_pay)
  );

  fs_slot #(.W(PW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctrl.out_load),
    .clr     (ctrl.out_clr),
    .d_valid (out_d_valid),
    .d_data  (out_d_pay),
    .q_valid (out_valid_o),
    .q_data  (out_pay)
  );

  assign {out_stop_o, out_addr_o, out_insn_o} = out_pay;

endmodule

// File: rtl/fetch_stash_chk.sv
module fetch_stash_chk #(
  parameter int ADDR_W = 64,
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              stall_i,
  input logic              in_valid_i,
  input logic [ADDR_W-1:0] in_addr_i,
  input logic              out_valid_o,
  input logic              out_stop_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [INSN_W-1:0] out_insn_o,
  input logic              stash_valid,
  input logic [ADDR_W-1:0] stash_addr
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!out_valid_o && !out_stop_o && out_addr_o == '0 && out_insn_o == '0);
    end
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !stall_i && !stash_valid) |=> (out_valid_o == $past(in_valid_i)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && stall_i) |=> ($stable(out_valid_o) && $stable(out_stop_o) &&
                               $stable(out_addr_o) && $stable(out_insn_o)));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && stall_i && in_valid_i && !stash_valid) |=>
      (stash_valid && stash_addr == $past(in_addr_i)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && stall_i && in_valid_i) |-> !stash_valid);

  p_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !stall_i && stash_valid) |=>
      (out_valid_o && out_addr_o == $past(stash_addr)));

  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !stall_i && stash_valid && in_valid_i) |=>
      (stash_valid && stash_addr == $past(in_addr_i)));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!out_valid_o && !stash_valid));

endmodule

bind fetch_stash fetch_stash_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_i     (flush_i),
  .stall_i     (stall_i),
  .in_valid_i  (in_valid_i),
  .in_addr_i   (in_addr_i),
  .out_valid_o (out_valid_o),
  .out_stop_o  (out_stop_o),
  .out_addr_o  (out_addr_o),
  .out_insn_o  (out_insn_o),
  .stash_valid (stash_valid),
  .stash_addr  (stash_addr)
);

// File: tb/test_fetch_stash.sv
module test_fetch_stash;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        stall_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_stop_i = 1'b0;
  logic [63:0] in_addr_i = '0;
  logic [31:0] in_insn_i = '0;
  logic        out_valid_o;
  logic        out_stop_o;
  logic [63:0] out_addr_o;
  logic [31:0] out_insn_o;

  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [63:0] nxt_addr = 64'h1000;
  logic [96:0] q[$];
  logic [97:0] prev = '0;

  always #5 clk = ~clk;

  fetch_stash i_fetch_stash (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .stall_i(stall_i),
    .in_valid_i(in_valid_i), .in_stop_i(in_stop_i), .in_addr_i(in_addr_i),
    .in_insn_i(in_insn_i), .out_valid_o(out_valid_o), .out_stop_o(out_stop_o),
    .out_addr_o(out_addr_o), .out_insn_o(out_insn_o)
  );

  task automatic chk(input string r, input logic [97:0] act, input logic [97:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [96:0] mk(input bit s);
    logic [96:0] p;
    p = {s, nxt_addr, $urandom};
    nxt_addr = nxt_addr + 64'd4;
    return p;
  endfunction

  // Called at a falling edge; drives one cycle and checks the result.
  task automatic cyc(input bit st, input bit fl, input bit v,
                     input logic [96:0] pay, input string tag);
    logic [96:0] cur;
    bit          exp_v;
    stall_i = st; flush_i = fl; in_valid_i = v;
    {in_stop_i, in_addr_i, in_insn_i} = pay;
    if (fl) q.delete();
    else if (v) q.push_back(pay);
    @(posedge clk);
    @(negedge clk);
    cur = {out_stop_o, out_addr_o, out_insn_o};
    if (fl) begin
      chk("R7", {97'd0, out_valid_o}, 98'd0);
    end else if (st) begin
      chk("R3", {out_valid_o, cur}, prev);
    end else begin
      exp_v = (q.size() != 0);
      chk(tag, {97'd0, out_valid_o}, {97'd0, exp_v});
      if (exp_v) begin
        chk(tag, {1'b0, cur}, {1'b0, q[0]});
        void'(q.pop_front());
      end
    end
    prev = {out_valid_o, cur};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit st, fl, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", {out_valid_o, out_stop_o, out_addr_o, out_insn_o}, 98'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: pass-through, stop marker carried
    cyc(0, 0, 1, mk(1'b1), "R2");
    cyc(0, 0, 1, mk(1'b0), "R2");
    // R9: bubble
    cyc(0, 0, 0, '0, "R9");
    // R4 capture during stall, R3 hold, R5 replay
    cyc(1, 0, 1, mk(1'b1), "R4");
    cyc(1, 0, 0, '0, "R4");
    cyc(0, 0, 0, '0, "R5");
    cyc(0, 0, 0, '0, "R9");
    // R6: live input during replay is kept and follows in order
    cyc(1, 0, 1, mk(1'b0), "R4");
    cyc(0, 0, 1, mk(1'b1), "R5");
    cyc(0, 0, 0, '0, "R6");
    // R7: flush with stall and a full stash drops everything
    cyc(1, 0, 1, mk(1'b0), "R4");
    cyc(1, 1, 1, mk(1'b1), "R7");
    cyc(0, 0, 0, '0, "R7");
    cyc(0, 1, 1, mk(1'b0), "R7");
    cyc(0, 0, 0, '0, "R7");
    // R8: random stalls, gaps and flushes
    for (int i = 0; i < 4000; i++) begin
      st = (($urandom % 10) < 3);
      fl = (($urandom % 50) == 0);
      v  = (($urandom % 10) < 8);
      if (st && !fl && q.size() != 0) v = 1'b0;
      if (v) cyc(st, fl, 1'b1, mk($urandom % 8 == 0), "R8");
      else   cyc(st, fl, 1'b0, '0, "R8");
    end
    cyc(0, 0, 0, '0, "R8");
    cyc(0, 0, 0, '0, "R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule